// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the serial front end of a small register core that sits on a two-wire bus as a slave. It runs on a fast system clock and samples the bus clock and data lines as ordinary inputs. It finds start and stop conditions and checks the address byte against a fixed device type and three strap pins. It then takes in an instruction byte and, depending on the command, either receives a 10-bit value in two bytes or sends one back. All bus output goes through a single pull-low enable, so the pad stays open-drain.

Toward the register core the block presents the opcode, a two-bit register pointer, the read/write flag from the address byte and the received value, and pulses a one-cycle execute strobe when a command is complete. Commands that change nonvolatile storage execute only at the stop that closes them. While the core reports that such a write is still running, the block leaves its own address unacknowledged, so the master can poll for completion.

Top module: `twowire_cmd_front`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Before the first start the block never pulls the line low. A stop returns it to idle, and a start always releases the line.
- R2: The address byte carries 0101 in bits 7:4, then bits 3:1 that must equal `strap_i`, then the read/write flag in bit 0 (1 = read). If the byte does not match, the block sends no acknowledge and ignores every byte until the next start.
- R3: The block acknowledges the matched address, the instruction byte and each data byte it receives. It asserts `sda_oe_o` after the clock falls at the end of the eighth bit and releases it after the clock falls at the end of the ninth. `sda_oe_o` changes only while the clock line is low.
- R4: When `core_busy_i` is high at the moment the address acknowledge would start, the block gives no address acknowledge. When it is low, a matching address is acknowledged normally.
- R5: In the instruction byte, bits 7:5 are the opcode and bits 3:2 the register pointer. Read flag 1 with an opcode other than 110 is a read with two bytes sent back. Read flag 1 with opcode 110, and read flag 0 with opcode 111, carry no data bytes, and any further byte is not acknowledged. Read flag 0 with any other opcode is followed by two data bytes.
- R6: A written value arrives MSB first. The low two bits of the first data byte become value bits 9:8, and its upper six bits are ignored. The second byte gives bits 7:0. The value is shown on `cmd_wdata_o` when the strobe fires.
- R7: For a read, `core_rdata_i` is captured in the cycle the strobe fires, after the instruction acknowledge. The block sends six 1 bits followed by value bits 9:8, then bits 7:0. Each bit is driven after the clock falls, and the line is released after every eight bits.
- R8: If the master does not acknowledge a byte the block has sent, the block drives nothing more until the next start.
- R9: `cmd_exec_o` is a one-cycle pulse. A non-store command raises it when its last acknowledge ends. A store command (read flag 0, opcode 110 or 111) raises it only at the stop that follows the complete command. A store cut short by a stop never raises it.
- R10: A start in the middle of a transaction drops the partial command and begins a new address byte.
- R11: After reset, `sda_oe_o` and `cmd_exec_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Board-set low address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| core_busy_i | input | 1 | Nonvolatile write in progress in the core |
| core_rdata_i | input | VAL_W | Value of the register the current command selects |
| cmd_exec_o | output | 1 | One-cycle execute strobe |
| cmd_rd_o | output | 1 | Read/write flag of the command |
| cmd_op_o | output | 3 | Opcode of the command |
| cmd_reg_o | output | 2 | Register pointer of the command |
| cmd_wdata_o | output | VAL_W | Value received for the command |

## Verification
The assertions check on every cycle that the pull-low enable moves only while the bus clock is low and is free after any start. They also check that the strobe lasts a single cycle, that a store strobe always follows a stop event, that the line is released when the strobe fires, and that no address acknowledge begins while the core is busy. Only the directed scenarios can show the actual byte contents: address matching against the straps, the split of the 10-bit value across two bytes in both directions, the class of each opcode, the silence after a master NACK, and the recovery after a repeated start.

// File: rtl/tw_pkg.sv
// Shared constants and types for the two-wire command front end.
// Assumes 8-bit bus bytes, a 4-bit device type and three strap bits.
package tw_pkg;

    localparam int          STRAP_W = 3;
    localparam logic [3:0]  DEV_ID  = 4'b0101;
    localparam logic [2:0]  OP_110  = 3'b110;   // load-type opcode with read flag set
    localparam logic [2:0]  OP_111  = 3'b111;   // store opcode without data

    typedef enum logic [2:0] {
        L_IDLE,
        L_RX,
        L_ACK,
        L_TX,
        L_MACK,
        L_DONE
    } link_st_t;

endpackage

// File: rtl/tw_pin_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// reports their edges, plus start and stop conditions.
// Assumes the system clock is several times faster than the bus clock;
// both lines pass through the same number of stages so their relative order holds.
module tw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic evt_start,
    output logic evt_stop
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q;
    logic       sda_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Purpose: metastability chain for one bus line, idles high.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    // Purpose: one-cycle history of both synchronized lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[0];
            sda_q <= synced[1];
        end
    end

    // Purpose: edge and bus-condition decode.
    always_comb begin
        sda_s     = synced[1];
        scl_rise  = synced[0] & ~scl_q;
        scl_fall  = ~synced[0] & scl_q;
        evt_start = synced[0] & scl_q & sda_q & ~synced[1];
        evt_stop  = synced[0] & scl_q & ~sda_q & synced[1];
    end

endmodule

// File: rtl/tw_decode.sv
// Combinational decode of the address byte and the command class.
// Assumes the address byte upper seven bits and the latched flag/opcode.
module tw_decode
    import tw_pkg::*;
(
    input  logic [6:0]         addr_hi,
    input  logic [STRAP_W-1:0] strap,
    input  logic               rw,
    input  logic [2:0]         op,
    output logic               addr_match,
    output logic               cls_read,
    output logic               cls_nodata,
    output logic               cls_store
);

    // Purpose: compare address and sort the command into its class.
    always_comb begin
        addr_match = (addr_hi == {DEV_ID, strap});
        cls_read   = rw && (op != OP_110);
        cls_nodata = rw ? (op == OP_110) : (op == OP_111);
        cls_store  = !rw && (op[2:1] == 2'b11);
    end

endmodule

// File: rtl/tw_link_fsm.sv
// Byte engine and command sequencer of the front end: shifts bits in and
// out, decides acknowledges, tracks byte position and fires the strobe.
// Assumes edge and condition events from tw_pin_sync and class bits from
// tw_decode; start and stop take priority over clock edges.
module tw_link_fsm
    import tw_pkg::*;
#(
    parameter int VAL_W = 10,
    localparam int HI_W = VAL_W - 8,
    localparam int PAD  = 8 - HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             evt_start,
    input  logic             evt_stop,
    input  logic             core_busy,
    input  logic [VAL_W-1:0] core_rdata,
    input  logic             addr_match,
    input  logic             cls_read,
    input  logic             cls_nodata,
    input  logic             cls_store,
    output logic [7:0]       shreg,
    output logic             rw_q,
    output logic [2:0]       op_q,
    output logic [1:0]       reg_q,
    output logic [VAL_W-1:0] wdata_q,
    output logic             exec_q,
    output logic             oe_q,
    output logic [1:0]       byte_idx
);

    link_st_t        st;
    logic [3:0]      bit_cnt;
    logic            byte_done;
    logic [HI_W-1:0] hi_q;
    logic [7:0]      tx_sr;
    logic [7:0]      lo_q;
    logic            tx_second;
    logic            macked;
    logic            store_pend;
    logic [7:0]      rd_hi_byte;

    // Purpose: first byte of a read reply, padded with released bits.
    assign rd_hi_byte = {{PAD{1'b1}}, core_rdata[VAL_W-1:8]};

    // Purpose: the whole link sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= L_IDLE;
            bit_cnt    <= '0;
            byte_done  <= 1'b0;
            byte_idx   <= '0;
            shreg      <= '0;
            rw_q       <= 1'b0;
            op_q       <= '0;
            reg_q      <= '0;
            hi_q       <= '0;
            wdata_q    <= '0;
            tx_sr      <= '0;
            lo_q       <= '0;
            tx_second  <= 1'b0;
            macked     <= 1'b0;
            store_pend <= 1'b0;
            exec_q     <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            exec_q <= 1'b0;
            if (evt_start) begin
                st         <= L_RX;
                bit_cnt    <= '0;
                byte_idx   <= '0;
                byte_done  <= 1'b0;
                oe_q       <= 1'b0;
                store_pend <= 1'b0;
            end else if (evt_stop) begin
                st         <= L_IDLE;
                oe_q       <= 1'b0;
                byte_done  <= 1'b0;
                exec_q     <= store_pend;
                store_pend <= 1'b0;
            end else begin
                case (st)
                    L_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            if (bit_cnt == 4'd7) begin
                                bit_cnt   <= '0;
                                byte_done <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end else if (scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            case (byte_idx)
                                2'd0: begin
                                    if (addr_match && !core_busy) begin
                                        rw_q <= shreg[0];
                                        oe_q <= 1'b1;
                                        st   <= L_ACK;
                                    end else begin
                                        st <= L_DONE;
                                    end
                                end
                                2'd1: begin
                                    op_q  <= shreg[7:5];
                                    reg_q <= shreg[3:2];
                                    oe_q  <= 1'b1;
                                    st    <= L_ACK;
                                end
                                2'd2: begin
                                    hi_q <= shreg[HI_W-1:0];
                                    oe_q <= 1'b1;
                                    st   <= L_ACK;
                                end
                                default: begin
                                    wdata_q <= {hi_q, shreg};
                                    oe_q    <= 1'b1;
                                    st      <= L_ACK;
                                end
                            endcase
                        end
                    end
                    L_ACK: begin
                        if (scl_fall) begin
                            oe_q <= 1'b0;
                            case (byte_idx)
                                2'd0: begin
                                    byte_idx <= 2'd1;
                                    st       <= L_RX;
                                end
                                2'd1: begin
                                    if (cls_read) begin
                                        exec_q    <= 1'b1;
                                        tx_sr     <= rd_hi_byte;
                                        lo_q      <= core_rdata[7:0];
                                        oe_q      <= ~rd_hi_byte[7];
                                        tx_second <= 1'b0;
                                        bit_cnt   <= '0;
                                        st        <= L_TX;
                                    end else if (cls_nodata) begin
                                        if (cls_store) store_pend <= 1'b1;
                                        else           exec_q     <= 1'b1;
                                        st <= L_DONE;
                                    end else begin
                                        byte_idx <= 2'd2;
                                        st       <= L_RX;
                                    end
                                end
                                2'd2: begin
                                    byte_idx <= 2'd3;
                                    st       <= L_RX;
                                end
                                default: begin
                                    if (cls_store) store_pend <= 1'b1;
                                    else           exec_q     <= 1'b1;
                                    st <= L_DONE;
                                end
                            endcase
                        end
                    end
                    L_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                oe_q    <= 1'b0;
                                bit_cnt <= '0;
                                st      <= L_MACK;
                            end else begin
                                oe_q  <= ~tx_sr[6];
                                tx_sr <= {tx_sr[6:0], 1'b1};
                            end
                        end
                    end
                    L_MACK: begin
                        if (scl_rise) begin
                            macked <= ~sda_s;
                        end else if (scl_fall) begin
                            if (macked && !tx_second) begin
                                tx_second <= 1'b1;
                                tx_sr     <= lo_q;
                                oe_q      <= ~lo_q[7];
                                st        <= L_TX;
                            end else begin
                                st <= L_DONE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/twowire_cmd_front.sv
// Top of the two-wire slave command front end: synchronizer, decoder and
// link sequencer. Assumes an external open-drain pad driven low by sda_oe_o
// and a register core that answers core_rdata_i combinationally from the
// presented command fields.
module twowire_cmd_front
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VAL_W       = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    input  logic               core_busy_i,
    input  logic [VAL_W-1:0]   core_rdata_i,
    output logic               cmd_exec_o,
    output logic               cmd_rd_o,
    output logic [2:0]         cmd_op_o,
    output logic [1:0]         cmd_reg_o,
    output logic [VAL_W-1:0]   cmd_wdata_o
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       evt_start;
    logic       evt_stop;
    logic [7:0] shreg;
    logic       addr_match;
    logic       cls_read;
    logic       cls_nodata;
    logic       cls_store;
    logic [1:0] byte_idx;

    tw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .evt_start (evt_start),
        .evt_stop  (evt_stop)
    );

    tw_decode u_dec (
        .addr_hi    (shreg[7:1]),
        .strap      (strap_i),
        .rw         (cmd_rd_o),
        .op         (cmd_op_o),
        .addr_match (addr_match),
        .cls_read   (cls_read),
        .cls_nodata (cls_nodata),
        .cls_store  (cls_store)
    );

    tw_link_fsm #(.VAL_W(VAL_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .evt_start  (evt_start),
        .evt_stop   (evt_stop),
        .core_busy  (core_busy_i),
        .core_rdata (core_rdata_i),
        .addr_match (addr_match),
        .cls_read   (cls_read),
        .cls_nodata (cls_nodata),
        .cls_store  (cls_store),
        .shreg      (shreg),
        .rw_q       (cmd_rd_o),
        .op_q       (cmd_op_o),
        .reg_q      (cmd_reg_o),
        .wdata_q    (cmd_wdata_o),
        .exec_q     (cmd_exec_o),
        .oe_q       (sda_oe_o),
        .byte_idx   (byte_idx)
    );

endmodule

// File: rtl/tw_front_checker.sv
// Protocol checker for twowire_cmd_front, attached by bind below.
// Assumes the bench never lets the master stop or start while the slave
// is pulling the line low.
module tw_front_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       core_busy_i,
    input logic       cmd_exec_o,
    input logic       cmd_rd_o,
    input logic [2:0] cmd_op_o,
    input logic       evt_start,
    input logic       evt_stop,
    input logic [1:0] byte_idx
);

    // R3: the pull-low enable moves only during the clock-low phase
    a_r3_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R1: a start always leaves the line released
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |=> !sda_oe_o);

    // R9: the strobe lasts exactly one cycle
    a_r9_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec_o |=> !cmd_exec_o);

    // R9: a store strobe follows a stop event
    a_r9_store_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exec_o && !cmd_rd_o && (cmd_op_o[2:1] == 2'b11)) |-> $past(evt_stop));

    // R4: no address acknowledge begins while the core is busy
    a_r4_busy_blocks_addr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && (byte_idx == 2'd0)) |-> $past(!core_busy_i));

    // R7: the line is free when the strobe fires (read padding is released)
    a_r7_exec_line_free: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec_o |-> !sda_oe_o);

endmodule

bind twowire_cmd_front tw_front_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .core_busy_i (core_busy_i),
    .cmd_exec_o  (cmd_exec_o),
    .cmd_rd_o    (cmd_rd_o),
    .cmd_op_o    (cmd_op_o),
    .evt_start   (evt_start),
    .evt_stop    (evt_stop),
    .byte_idx    (byte_idx)
);

// File: tb/twowire_cmd_front_bench.sv
// Directed bench: a bus master model drives the lines, one task per scenario.
module twowire_cmd_front_bench;

    localparam int         Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       busy = 1'b0;
    logic [9:0] rd_val = '0;
    logic       sda_oe;
    logic       ex;
    logic       ex_rd_w;
    logic [2:0] ex_op_w;
    logic [1:0] ex_reg_w;
    logic [9:0] ex_wd_w;
    wire        sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int exec_cnt = 0;
    logic       ex_rd;
    logic [2:0] ex_op;
    logic [1:0] ex_reg;
    logic [9:0] ex_wd;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twowire_cmd_front u_twowire_cmd_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .strap_i      (STRAP),
        .sda_oe_o     (sda_oe),
        .core_busy_i  (busy),
        .core_rdata_i (rd_val),
        .cmd_exec_o   (ex),
        .cmd_rd_o     (ex_rd_w),
        .cmd_op_o     (ex_op_w),
        .cmd_reg_o    (ex_reg_w),
        .cmd_wdata_o  (ex_wd_w)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && ex) begin
            exec_cnt = exec_cnt + 1;
            ex_rd  = ex_rd_w;
            ex_op  = ex_op_w;
            ex_reg = ex_reg_w;
            ex_wd  = ex_wd_w;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hold();
            m_scl = 1'b1; hold(); hold();
            m_scl = 1'b0; hold();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        ack = ~sda_line; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; hold();
            m_scl = 1'b1; hold();
            b[i] = sda_line; hold();
            m_scl = 1'b0; hold();
        end
        m_sda = ~mack; hold();
        m_scl = 1'b1; hold(); hold();
        m_scl = 1'b0; hold();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic rw);
        return {4'b0101, STRAP, rw};
    endfunction

    task automatic t_reset();
        check("R11 oe after reset", int'(sda_oe), 0);
        check("R11 exec after reset", int'(ex), 0);
    endtask

    task automatic t_no_start();
        logic a;
        m_scl = 1'b0; hold();
        send_byte(addr_byte(1'b0), a);
        m_scl = 1'b1; hold();
        check("R1 no ack before start", int'(a), 0);
    endtask

    task automatic t_write_wcr();
        logic a0, a1, a2, a3;
        int e0 = exec_cnt;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'hA0, a1);
        send_byte(8'hFE, a2);
        check("R9 no strobe before last byte", exec_cnt, e0);
        send_byte(8'hA5, a3);
        check("R3 acks on write", int'({a0, a1, a2, a3}), 4'hF);
        check("R9 strobe after last ack", exec_cnt, e0 + 1);
        check("R6 write value", int'(ex_wd), 10'h2A5);
        check("R5 write opcode", int'(ex_op), 3'b101);
        check("R5 write flag", int'(ex_rd), 0);
        bus_stop();
        check("R9 no strobe at plain stop", exec_cnt, e0 + 1);
    endtask

    task automatic t_bad_addr();
        logic a0, a1, a2;
        int e0 = exec_cnt;
        bus_start();
        send_byte({4'b0101, 3'b100, 1'b0}, a0);
        send_byte(8'hA0, a1);
        bus_stop();
        bus_start();
        send_byte({4'b0110, STRAP, 1'b0}, a2);
        bus_stop();
        check("R2 strap mismatch nack", int'(a0), 0);
        check("R2 following byte ignored", int'(a1), 0);
        check("R2 device type mismatch nack", int'(a2), 0);
        check("R2 no strobe", exec_cnt, e0);
    endtask

    task automatic t_busy();
        logic a0, a1;
        busy = 1'b1;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(addr_byte(1'b0), a1);
        bus_stop();
        check("R4 busy address nack", int'(a0), 0);
        check("R4 idle address ack", int'(a1), 1);
    endtask

    task automatic t_read();
        logic a0, a1;
        logic [7:0] b1, b2;
        int e0 = exec_cnt;
        rd_val = 10'h1C3;
        bus_start();
        send_byte(addr_byte(1'b1), a0);
        send_byte(8'hA8, a1);
        rd_val = 10'h000;
        check("R5 read header acks", int'({a0, a1}), 2'b11);
        check("R9 read strobe", exec_cnt, e0 + 1);
        check("R5 read fields", int'({ex_rd, ex_op, ex_reg}), {1'b1, 3'b101, 2'b10});
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        check("R7 read high byte", int'(b1), 8'hFD);
        check("R7 read low byte", int'(b2), 8'hC3);
    endtask

    task automatic t_read_nack();
        logic a0, a1;
        logic [7:0] b1, b2;
        rd_val = 10'h300;
        bus_start();
        send_byte(addr_byte(1'b1), a0);
        send_byte(8'h80, a1);
        recv_byte(1'b0, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        check("R7 read high byte", int'(b1), 8'hFF);
        check("R8 silent after master nack", int'(b2), 8'hFF);
    endtask

    task automatic t_store();
        logic a0, a1, a2, a3;
        int e0 = exec_cnt;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'hC4, a1);
        send_byte(8'hFD, a2);
        send_byte(8'h3C, a3);
        check("R3 acks on store", int'({a0, a1, a2, a3}), 4'hF);
        check("R9 store waits for stop", exec_cnt, e0);
        bus_stop();
        check("R9 store strobe at stop", exec_cnt, e0 + 1);
        check("R6 store value", int'(ex_wd), 10'h13C);
        check("R5 store fields", int'({ex_rd, ex_op, ex_reg}), {1'b0, 3'b110, 2'b01});
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'hC8, a1);
        send_byte(8'hFF, a2);
        bus_stop();
        check("R9 aborted store no strobe", exec_cnt, e0 + 1);
    endtask

    task automatic t_nodata();
        logic a0, a1, a2, a3, a4;
        int e0 = exec_cnt;
        bus_start();
        send_byte(addr_byte(1'b1), a0);
        send_byte(8'hCC, a1);
        check("R9 load strobe after instruction", exec_cnt, e0 + 1);
        check("R5 load fields", int'({ex_rd, ex_op, ex_reg}), {1'b1, 3'b110, 2'b11});
        send_byte(8'h55, a2);
        bus_stop();
        check("R5 no data byte after load", int'(a2), 0);
        bus_start();
        send_byte(addr_byte(1'b0), a3);
        send_byte(8'hE4, a4);
        check("R9 transfer store waits", exec_cnt, e0 + 1);
        bus_stop();
        check("R9 transfer store at stop", exec_cnt, e0 + 2);
        check("R5 transfer store fields", int'({ex_rd, ex_op, ex_reg}), {1'b0, 3'b111, 2'b01});
        check("R3 acks on header", int'({a0, a1, a3, a4}), 4'hF);
    endtask

    task automatic t_restart();
        logic a0, a1, a2, a3, a4;
        int e0 = exec_cnt;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_bits(8'hA0, 4);
        bus_start();
        send_byte(addr_byte(1'b0), a1);
        send_byte(8'hA0, a2);
        send_byte(8'hFC, a3);
        send_byte(8'hC3, a4);
        bus_stop();
        check("R10 acks after repeated start", int'({a1, a2, a3, a4}), 4'hF);
        check("R10 one strobe", exec_cnt, e0 + 1);
        check("R10 value after restart", int'(ex_wd), 10'h0C3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_no_start();
        t_write_wcr();
        t_bad_addr();
        t_busy();
        t_read();
        t_read_nack();
        t_store();
        t_nodata();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule